// File: doc/BRIEF.md
# Power Stage Fault Recovery Controller

This block supervises an output power stage through an active-low fault line that the stage pulls low on overcurrent or thermal overload. While the fault is present, the controller drives the stage's active-low 3-state control low for a fixed 1 ms, then releases it high for one clock. In that clock it looks at the fault line again. If the fault is still present, another hold starts at once. If it has cleared, the controller returns to idle. For the whole of a recovery episode a fault interrupt output stays high.

An active-low power-down input takes priority over everything else. It forces the 3-state control low, clears the interrupt, deasserts the PLL enable and restarts the recovery timer. The fault line passes through a two-flop synchronizer. The 1 ms interval is a cycle count derived from the clock-frequency parameter and the hold length in microseconds.

The states are POWERED_DOWN, IDLE, RECOVER_HOLD and RELEASE. A synchronous active-low reset enters POWERED_DOWN. The named transitions are:
- wake: POWERED_DOWN to IDLE, when power-down is high.
- trip: IDLE to RECOVER_HOLD, when the synchronized fault is seen.
- expire: RECOVER_HOLD to RELEASE, when the hold count ends.
- retry: RELEASE to RECOVER_HOLD, when the fault is still present.
- clear: RELEASE to IDLE, when the fault is gone.
- sleep: any state to POWERED_DOWN, when power-down is low.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: With reset_n low at a clock edge, the block enters POWERED_DOWN, in which tristate_n_o=0, fault_irq_o=0 and pll_en_o=0.
- R2: In IDLE with pwrdn_n_i=1, a 0 on fault_n_i makes tristate_n_o fall and fault_irq_o rise after the third rising edge that follows the change (two synchronizer flops plus the state register).
- R3: In RECOVER_HOLD, tristate_n_o stays 0 for exactly HOLD_CYCLES = (CLK_FREQ_HZ/1000000)*HOLD_US cycles. It then reads 1 for exactly one cycle (RELEASE).
- R4: If the synchronized fault is still 0 during the RELEASE cycle, the next cycle is RECOVER_HOLD again with a full-length hold. The pulses repeat while the fault persists.
- R5: fault_irq_o is 1 in RECOVER_HOLD and RELEASE and 0 otherwise. If the fault has cleared during RELEASE, the next cycle is IDLE with fault_irq_o=0.
- R6: pwrdn_n_i=0 at a rising edge puts the block in POWERED_DOWN from any state after that edge. The recovery timer restarts, so a later hold lasts a full HOLD_CYCLES.
- R7: pll_en_o is 0 in POWERED_DOWN and 1 in every other state.
- R8: In POWERED_DOWN, pwrdn_n_i=1 at a rising edge moves the block to IDLE, where tristate_n_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_n_i | input | 1 | Asynchronous active-low fault from the power stage |
| pwrdn_n_i | input | 1 | Active-low power-down (0 = low power, 1 = run) |
| tristate_n_o | output | 1 | Active-low 3-state control to the power stage |
| fault_irq_o | output | 1 | Fault interrupt, high during recovery |
| pll_en_o | output | 1 | PLL enable, low in power-down |

## Verification
A fault edge reaches the outputs three rising edges later, and a power-down or wake level is seen one edge later. A hold lasts exactly HOLD_CYCLES, and the release pulse lasts exactly one cycle. The bench keeps a behavioural model that advances on each rising edge with the same register count. It compares all three outputs at every falling edge, so each result is checked in the cycle it falls due. Directed tasks also count falling edges from each stimulus to measure trip latency and hold length directly.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [1:0] {
        ST_POWERED_DOWN = 2'd0,
        ST_IDLE         = 2'd1,
        ST_RECOVER_HOLD = 2'd2,
        ST_RELEASE      = 2'd3
    } pfs_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfs_hold_timer.sv
module pfs_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_idle_cnt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
    import pfs_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 125_000_000,
    parameter int unsigned HOLD_US     = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n_i,
    input  logic pwrdn_n_i,
    output logic tristate_n_o,
    output logic fault_irq_o,
    output logic pll_en_o
);
    localparam int unsigned TICKS_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int unsigned HOLD_RAW     = TICKS_PER_US * HOLD_US;
    localparam int unsigned HOLD_CYCLES  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

    pfs_state_e state_q, state_d;
    logic       fault_n_s;
    logic       fault_s;
    logic       hold_done;

    pfs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (fault_n_i),
        .q_o   (fault_n_s)
    );

    assign fault_s = !fault_n_s;

    pfs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_RECOVER_HOLD),
        .done_o (hold_done)
    );

    always_comb begin
        state_d = state_q;
        if (!pwrdn_n_i) begin
            state_d = ST_POWERED_DOWN;                      // sleep
        end else begin
            unique case (state_q)
                ST_POWERED_DOWN: state_d = ST_IDLE;         // wake
                ST_IDLE:         if (fault_s) state_d = ST_RECOVER_HOLD;   // trip
                ST_RECOVER_HOLD: if (hold_done) state_d = ST_RELEASE;      // expire
                ST_RELEASE:      state_d = fault_s ? ST_RECOVER_HOLD       // retry
                                                   : ST_IDLE;              // clear
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_POWERED_DOWN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        tristate_n_o = 1'b0;
        fault_irq_o  = 1'b0;
        pll_en_o     = 1'b1;
        unique case (state_q)
            ST_POWERED_DOWN: pll_en_o = 1'b0;
            ST_IDLE:         tristate_n_o = 1'b1;
            ST_RECOVER_HOLD: fault_irq_o = 1'b1;
            ST_RELEASE: begin
                tristate_n_o = 1'b1;
                fault_irq_o  = 1'b1;
            end
        endcase
    end

    assert_pwrdn_forces_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n_i |=> (!tristate_n_o && !pll_en_o && !fault_irq_o));

    assert_release_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RELEASE |=> state_q != ST_RELEASE);

    assert_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && fault_s && pwrdn_n_i) |=> (state_q == ST_RECOVER_HOLD && !tristate_n_o));

    assert_clear_to_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && !fault_s && pwrdn_n_i) |=> (!fault_irq_o && tristate_n_o));

    assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POWERED_DOWN && pwrdn_n_i) |=> (tristate_n_o && pll_en_o));
endmodule

// File: tb/tb_pwr_fault_supervisor.sv
module tb_pwr_fault_supervisor;
    localparam int CLK_HZ = 8_000_000;
    localparam int HUS    = 2;
    localparam int HOLD   = (CLK_HZ / 1_000_000) * HUS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_n = 1'b1;
    logic pwrdn_n = 1'b0;
    logic ts, irq, pll;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    // model: 0 powered down, 1 idle, 2 hold, 3 release
    int m_state = 0;
    int m_cnt = 0;
    bit m_f1 = 1'b1;
    bit m_f2 = 1'b1;

    always #4 clk = ~clk;

    pwr_fault_supervisor #(.CLK_FREQ_HZ(CLK_HZ), .HOLD_US(HUS)) dut (
        .clk(clk), .rst_n(rst_n), .fault_n_i(fault_n), .pwrdn_n_i(pwrdn_n),
        .tristate_n_o(ts), .fault_irq_o(irq), .pll_en_o(pll)
    );

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_f1 = 1'b1; m_f2 = 1'b1;
        end else begin
            if (!pwrdn_n) begin
                m_state = 0; m_cnt = 0;
            end else begin
                case (m_state)
                    0: m_state = 1;
                    1: if (!m_f2) begin m_state = 2; m_cnt = 0; end
                    2: if (m_cnt == HOLD - 1) begin m_state = 3; m_cnt = 0; end
                       else m_cnt++;
                    default: begin m_state = !m_f2 ? 2 : 1; m_cnt = 0; end
                endcase
            end
            m_f2 = m_f1;
            m_f1 = fault_n;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R3 tristate vs model", ts, (m_state == 1 || m_state == 3));
            chk("R5 irq vs model", irq, (m_state == 2 || m_state == 3));
            chk("R7 pll_en vs model", pll, (m_state != 0));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_low(output int lat);
        lat = 0;
        do begin @(negedge clk); lat++; end while (ts && lat < 50);
    endtask

    task automatic measure_low(output int len);
        len = 0;
        while (!ts && len < 200) begin len++; @(negedge clk); end
    endtask

    initial begin
        int lat, len;
        @(negedge clk);
        cycles(3);
        chk("R1 reset tristate", ts, 1'b0);
        chk("R1 reset irq", irq, 1'b0);
        chk("R1 reset pll", pll, 1'b0);
        rst_n = 1'b1;
        cycles(3);
        chk("R6 held powered down pll", pll, 1'b0);
        pwrdn_n = 1'b1;
        cycles(1);
        chk("R8 wake tristate", ts, 1'b1);
        chk("R8 wake pll", pll, 1'b1);
        cycles(4);
        // trip and repeated retries
        fault_n = 1'b0;
        wait_low(lat);
        chk_int("R2 trip latency", lat, 3);
        chk("R2 irq on trip", irq, 1'b1);
        measure_low(len);
        chk_int("R3 hold length", len, HOLD);
        chk("R3 release high", ts, 1'b1);
        chk("R5 irq in release", irq, 1'b1);
        cycles(1);
        chk("R4 retry low again", ts, 1'b0);
        measure_low(len);
        chk_int("R4 second hold length", len, HOLD);
        cycles(1);
        // clear during the third hold
        fault_n = 1'b1;
        measure_low(len);
        chk("R5 final release irq", irq, 1'b1);
        cycles(1);
        chk("R5 idle irq cleared", irq, 1'b0);
        chk("R5 idle tristate high", ts, 1'b1);
        cycles(3);
        // power-down mid-hold
        fault_n = 1'b0;
        wait_low(lat);
        cycles(5);
        pwrdn_n = 1'b0;
        cycles(1);
        chk("R6 pd tristate", ts, 1'b0);
        chk("R6 pd irq", irq, 1'b0);
        chk("R7 pd pll", pll, 1'b0);
        cycles(3);
        pwrdn_n = 1'b1;
        wait_low(lat);
        chk_int("R6 wake to hold latency", lat, 2);
        measure_low(len);
        chk_int("R6 timer restarted full hold", len, HOLD);
        fault_n = 1'b1;
        cycles(HOLD * 2 + 6);
        chk("R5 back to idle", irq, 1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule